// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models the command interface of a parallel NOR flash device behind a word-wide memory port. Writes to the port are command bytes (taken from the low 8 bits of the write data) or the operands that follow them. A latched command byte and a two-bit phase counter steer each multi-write sequence: single-word program, sector erase, buffered write with a word count, lock/unlock acceptance, and clearing of the status register. The latched command also decides what a read returns: stored array data, the 8-bit status register, identification codes or query bytes. A `read_only` pin turns every storing operation into an error report.

The bank is `BANK_BYTES` wide. It is built from devices that are each `DEV_BYTES` wide, and every device lane of a non-array read carries the same zero-extended byte. Addresses are word addresses into an on-chip array of `WORDS` entries. A sector is `SECTOR_WORDS` words, a power of two, and erasing one writes a single word of all ones per cycle. The request side is valid/ready. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while a sector fill is running, and the requester must then hold the request steady. Read responses carry no back-pressure: `rsp_valid` is high for exactly one cycle, and the consumer must take the data in that cycle.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block is in array-read mode with the phase at 0, and the status register holds 0x80.
- R2: A write of 0xFF, 0xF0 or 0x00 in phase 0 selects array-read mode. Reads in that mode return the stored word.
- R3: A write of 0x70 in phase 0 selects status reads and leaves the phase at 0. A write of 0x90 selects ID reads and also leaves the phase at 0. In ID mode, word 0 returns `MFR_ID`, word 1 returns `DEV_ID` and any other word returns 0.
- R4: 0x98 selects query mode and moves to phase 1. Query words 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59. Word 0x27 returns log2(WORDS*DEV_BYTES). In query mode a later write of 0xFF selects array-read mode, and any other write leaves query mode unchanged.
- R5: 0x10 or 0x40 arms a program. The next write stores its full data word at its address, sets status bit 7 and returns to phase 0. Reads then return status until another command is written. Status bit 7, once set, clears only through 0x50.
- R6: 0x20 erases the sector that holds the address, aligned down to `SECTOR_WORDS`, and sets status bit 7. `req_ready` is low for exactly `SECTOR_WORDS` cycles after the accepting edge. The next write must be 0xD0 (back to phase 0) or 0xFF. Any other value selects array-read mode.
- R7: 0x50 clears the whole status register to 0x00 and selects array-read mode.
- R8: After 0x60, a second write of 0xD0 or 0x01 sets status bit 7 and returns to phase 0 with status reads. Any other second write selects array-read mode.
- R9: 0xE8 sets status bit 7. The next write gives a count N, taken from the low DEV_BYTES*8 bits of its data. The next N+1 writes store their data. A write of 0xD0 after them returns to phase 0, and any other value selects array-read mode; data already stored stays stored.
- R10: While `read_only` is high, the array is never written. A program data write or a buffered data write sets status bit 4. An erase sets status bit 5 and does not drop `req_ready`.
- R11: A command byte not listed in R2 to R9, written in phase 0, selects array-read mode.
- R12: A status, ID or query read places its zero-extended byte in every DEV_BYTES-wide lane of the response.
- R13: Each accepted read gives `rsp_valid` high for exactly the one cycle after the accepting edge, with its data. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| read_only | input | 1 | Blocks every array write and reports errors instead |
| req_valid | input | 1 | A request is presented |
| req_ready | output | 1 | Low while a sector fill runs |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | $clog2(WORDS) | Word address |
| req_wdata | input | BANK_BYTES*8 | Command byte (low 8 bits), operand or data |
| rsp_valid | output | 1 | Read data valid for one cycle |
| rsp_data | output | BANK_BYTES*8 | Read result |

## Verification
The assertions check these rules on every cycle: the status clear and its return to array mode; that status and ID selection keep the phase at 0; that the ready bit never drops except through a clear; that a fill starts only from an accepted erase on a writable device; that the array is never written under `read_only`; and that each response follows exactly one read. The stored contents can only be shown by the bench's scenarios. These include sector alignment, the N+1 beat count with its masking, aborted confirms that keep their data, and the per-lane replication of the returned bytes.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_ARG     = 2'd1,
    PH_DATA    = 2'd2,
    PH_CONFIRM = 2'd3
  } phase_t;

  localparam logic [7:0] OP_READ      = 8'h00;
  localparam logic [7:0] OP_UNLOCK2   = 8'h01;
  localparam logic [7:0] OP_PROG_A    = 8'h10;
  localparam logic [7:0] OP_ERASE     = 8'h20;
  localparam logic [7:0] OP_ERASE_ALT = 8'h28;
  localparam logic [7:0] OP_PROG_B    = 8'h40;
  localparam logic [7:0] OP_CLEAR     = 8'h50;
  localparam logic [7:0] OP_LOCK      = 8'h60;
  localparam logic [7:0] OP_STATUS    = 8'h70;
  localparam logic [7:0] OP_IDENT     = 8'h90;
  localparam logic [7:0] OP_QUERY     = 8'h98;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;
  localparam logic [7:0] OP_BUFFER    = 8'hE8;
  localparam logic [7:0] OP_READ_ALT  = 8'hF0;
  localparam logic [7:0] OP_READ_STD  = 8'hFF;

  localparam int ST_READY = 7;
  localparam int ST_EERR  = 5;
  localparam int ST_PERR  = 4;

  function automatic logic shows_status(input logic [7:0] op);
    case (op)
      OP_PROG_A, OP_ERASE, OP_ERASE_ALT, OP_PROG_B,
      OP_CLEAR, OP_LOCK, OP_STATUS, OP_BUFFER: return 1'b1;
      default:                                 return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/nor_seq_store.sv
module nor_seq_store #(
  parameter int WORDS = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int AW           = 6,
  parameter int DW           = 32,
  parameter int DEVW         = 16,
  parameter int SECTOR_WORDS = 8,
  localparam int SB          = $clog2(SECTOR_WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          read_only,
  input  logic          wr_fire,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          busy,
  output logic [7:0]    cur_cmd,
  output logic [7:0]    status,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata
);

  logic [7:0]       cmd_q, cmd_d;
  phase_t           ph_q, ph_d;
  logic [7:0]       st_q, st_d;
  logic [DEVW-1:0]  cnt_q, cnt_d;
  logic             fill_q;
  logic [SB-1:0]    ptr_q;
  logic [AW-SB-1:0] sec_q;
  logic             start_fill, data_we, to_array;
  logic [7:0]       op;

  assign op = wr_data[7:0];

  always_comb begin
    cmd_d = cmd_q; ph_d = ph_q; st_d = st_q; cnt_d = cnt_q;
    start_fill = 1'b0; data_we = 1'b0; to_array = 1'b0;
    if (wr_fire) begin
      unique case (ph_q)
        PH_IDLE: begin
          case (op)
            OP_READ, OP_READ_ALT, OP_READ_STD: to_array = 1'b1;
            OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
              cmd_d = op; ph_d = PH_ARG;
            end
            OP_ERASE: begin
              cmd_d = op; ph_d = PH_ARG; st_d[ST_READY] = 1'b1;
              if (read_only) st_d[ST_EERR] = 1'b1;
              else           start_fill = 1'b1;
            end
            OP_CLEAR: begin st_d = '0; to_array = 1'b1; end
            OP_STATUS, OP_IDENT: cmd_d = op;
            OP_BUFFER: begin
              cmd_d = op; ph_d = PH_ARG; st_d[ST_READY] = 1'b1;
            end
            default: to_array = 1'b1;
          endcase
        end
        PH_ARG: begin
          case (cmd_q)
            OP_PROG_A, OP_PROG_B: begin
              if (read_only) st_d[ST_PERR] = 1'b1;
              else           data_we = 1'b1;
              st_d[ST_READY] = 1'b1; ph_d = PH_IDLE;
            end
            OP_ERASE, OP_ERASE_ALT: begin
              if (op == OP_CONFIRM) begin ph_d = PH_IDLE; st_d[ST_READY] = 1'b1; end
              else to_array = 1'b1;
            end
            OP_BUFFER: begin cnt_d = wr_data[DEVW-1:0]; ph_d = PH_DATA; end
            OP_LOCK: begin
              if (op == OP_CONFIRM || op == OP_UNLOCK2) begin
                ph_d = PH_IDLE; st_d[ST_READY] = 1'b1;
              end else to_array = 1'b1;
            end
            OP_QUERY: if (op == OP_READ_STD) to_array = 1'b1;
            default: to_array = 1'b1;
          endcase
        end
        PH_DATA: begin
          if (cmd_q == OP_BUFFER) begin
            if (read_only) st_d[ST_PERR] = 1'b1;
            else           data_we = 1'b1;
            st_d[ST_READY] = 1'b1;
            if (cnt_q == '0) ph_d = PH_CONFIRM;
            cnt_d = cnt_q - 1'b1;
          end else to_array = 1'b1;
        end
        PH_CONFIRM: begin
          if (cmd_q == OP_BUFFER && op == OP_CONFIRM) ph_d = PH_IDLE;
          else to_array = 1'b1;
        end
      endcase
      if (to_array) begin cmd_d = OP_READ; ph_d = PH_IDLE; end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= OP_READ; ph_q <= PH_IDLE; st_q <= 8'h80; cnt_q <= '0;
      fill_q <= 1'b0; ptr_q <= '0; sec_q <= '0;
    end else begin
      cmd_q <= cmd_d; ph_q <= ph_d; st_q <= st_d; cnt_q <= cnt_d;
      if (start_fill) begin
        fill_q <= 1'b1; ptr_q <= '0; sec_q <= wr_addr[AW-1:SB];
      end else if (fill_q) begin
        ptr_q <= ptr_q + 1'b1;
        if (ptr_q == SB'(SECTOR_WORDS - 1)) fill_q <= 1'b0;
      end
    end
  end

  assign busy      = fill_q;
  assign cur_cmd   = cmd_q;
  assign status    = st_q;
  assign mem_we    = fill_q | data_we;
  assign mem_addr  = fill_q ? {sec_q, ptr_q} : wr_addr;
  assign mem_wdata = fill_q ? '1 : wr_data;

  // R7
  clear_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && ph_q == PH_IDLE && op == OP_CLEAR) |=> (status == 8'h00 && cur_cmd == OP_READ));

  // R3
  select_keeps_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && ph_q == PH_IDLE && (op == OP_STATUS || op == OP_IDENT)) |=> ph_q == PH_IDLE);

  // R5
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(st_q[ST_READY]) |-> $past(wr_fire && ph_q == PH_IDLE && op == OP_CLEAR));

  // R6
  fill_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fill_q) |-> $past(wr_fire && ph_q == PH_IDLE && op == OP_ERASE && !read_only));

endmodule

// File: rtl/nor_seq_rdmux.sv
module nor_seq_rdmux
  import nor_seq_pkg::*;
#(
  parameter int AW              = 6,
  parameter int DW              = 32,
  parameter int DEVW            = 16,
  parameter logic [7:0] MFR_ID  = 8'h89,
  parameter logic [7:0] DEV_ID  = 8'h18,
  parameter logic [7:0] SIZE_CODE = 8'd7,
  localparam int LANES          = DW / DEVW
) (
  input  logic [7:0]    sel_cmd,
  input  logic [AW-1:0] sel_addr,
  input  logic [7:0]    sel_status,
  input  logic [DW-1:0] array_q,
  output logic [DW-1:0] rdata
);

  logic [31:0]   ax;
  logic [7:0]    rbyte;
  logic          from_array;
  logic [DW-1:0] rep;

  always_comb begin
    ax = 32'(sel_addr);
    rbyte = 8'h00;
    from_array = 1'b0;
    if (shows_status(sel_cmd)) begin
      rbyte = sel_status;
    end else if (sel_cmd == OP_IDENT) begin
      if (ax == 32'd0)      rbyte = MFR_ID;
      else if (ax == 32'd1) rbyte = DEV_ID;
    end else if (sel_cmd == OP_QUERY) begin
      case (ax)
        32'h10:  rbyte = 8'h51;
        32'h11:  rbyte = 8'h52;
        32'h12:  rbyte = 8'h59;
        32'h13:  rbyte = 8'h01;
        32'h27:  rbyte = SIZE_CODE;
        32'h2C:  rbyte = 8'h01;
        default: rbyte = 8'h00;
      endcase
    end else begin
      from_array = 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rep[g*DEVW +: DEVW] = DEVW'(rbyte);
  end

  assign rdata = from_array ? array_q : rep;

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int BANK_BYTES     = 4,
  parameter int DEV_BYTES      = 2,
  parameter int WORDS          = 64,
  parameter int SECTOR_WORDS   = 8,
  parameter logic [7:0] MFR_ID = 8'h89,
  parameter logic [7:0] DEV_ID = 8'h18,
  localparam int DW            = BANK_BYTES * 8,
  localparam int DEVW          = DEV_BYTES * 8,
  localparam int AW            = $clog2(WORDS),
  localparam logic [7:0] SIZE_CODE = 8'($clog2(WORDS * DEV_BYTES))
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          read_only,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);

  logic          busy, wr_fire, rd_fire;
  logic [7:0]    cur_cmd, status;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, array_q;
  logic [7:0]    rd_cmd_q, rd_st_q;
  logic [AW-1:0] rd_addr_q;
  logic          rsp_q;

  assign req_ready = !busy;
  assign wr_fire   = req_valid && req_ready && req_write;
  assign rd_fire   = req_valid && req_ready && !req_write;

  nor_seq_ctrl #(.AW(AW), .DW(DW), .DEVW(DEVW), .SECTOR_WORDS(SECTOR_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .read_only(read_only), .wr_fire(wr_fire),
    .wr_addr(req_addr), .wr_data(req_wdata), .busy(busy), .cur_cmd(cur_cmd),
    .status(status), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  nor_seq_store #(.WORDS(WORDS), .DW(DW)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(req_addr), .rdata(array_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= 1'b0; rd_cmd_q <= OP_READ; rd_st_q <= '0; rd_addr_q <= '0;
    end else begin
      rsp_q <= rd_fire;
      if (rd_fire) begin
        rd_cmd_q <= cur_cmd; rd_st_q <= status; rd_addr_q <= req_addr;
      end
    end
  end

  nor_seq_rdmux #(.AW(AW), .DW(DW), .DEVW(DEVW), .MFR_ID(MFR_ID), .DEV_ID(DEV_ID),
                  .SIZE_CODE(SIZE_CODE)) u_rdmux (
    .sel_cmd(rd_cmd_q), .sel_addr(rd_addr_q), .sel_status(rd_st_q),
    .array_q(array_q), .rdata(rsp_data)
  );

  assign rsp_valid = rsp_q;

  // R10
  ro_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && read_only) |-> !mem_we);

  // R13
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rsp_valid);

  // R13
  rsp_only_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(rd_fire));

endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;

  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          read_only = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready, rsp_valid;
  logic [DW-1:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  nor_cmd_seq u_dut (
    .clk(clk), .rst_n(rst_n), .read_only(read_only), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  typedef struct packed {
    logic          rd;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [3:0]    rq;
  } vec_t;

  localparam int NV = 63;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 6'd0,  32'hFF, 4'd2},
    '{1'b0, 6'd8,  32'h20, 4'd6},
    '{1'b0, 6'd8,  32'hD0, 4'd6},
    '{1'b0, 6'd0,  32'hFF, 4'd2},
    '{1'b1, 6'd13, 32'hFFFFFFFF, 4'd6},   // R6 erased word
    '{1'b0, 6'd10, 32'h40, 4'd5},
    '{1'b0, 6'd10, 32'h12345678, 4'd5},
    '{1'b1, 6'd10, 32'h00800080, 4'd5},   // R5 status after program
    '{1'b0, 6'd0,  32'hFF, 4'd2},
    '{1'b1, 6'd10, 32'h12345678, 4'd5},   // R5 stored word
    '{1'b1, 6'd11, 32'hFFFFFFFF, 4'd6},
    '{1'b0, 6'd0,  32'h10, 4'd5},
    '{1'b0, 6'd11, 32'hCAFEF00D, 4'd5},
    '{1'b0, 6'd0,  32'hF0, 4'd2},
    '{1'b1, 6'd11, 32'hCAFEF00D, 4'd2},   // R2 via 0xF0
    '{1'b0, 6'd0,  32'h90, 4'd3},
    '{1'b1, 6'd0,  32'h00890089, 4'd3},   // R3 manufacturer code
    '{1'b1, 6'd1,  32'h00180018, 4'd3},
    '{1'b1, 6'd2,  32'h00000000, 4'd3},
    '{1'b0, 6'd0,  32'h98, 4'd4},
    '{1'b1, 6'h10, 32'h00510051, 4'd4},   // R4 query text
    '{1'b0, 6'd0,  32'h55, 4'd4},
    '{1'b1, 6'h12, 32'h00590059, 4'd4},
    '{1'b1, 6'h27, 32'h00070007, 4'd4},
    '{1'b0, 6'd0,  32'hFF, 4'd4},
    '{1'b1, 6'd10, 32'h12345678, 4'd4},
    '{1'b0, 6'd0,  32'h50, 4'd7},
    '{1'b1, 6'd10, 32'h12345678, 4'd7},   // R7 array mode after clear
    '{1'b0, 6'd0,  32'h70, 4'd7},
    '{1'b1, 6'd0,  32'h00000000, 4'd7},
    '{1'b0, 6'd0,  32'h60, 4'd8},
    '{1'b0, 6'd0,  32'hD0, 4'd8},
    '{1'b1, 6'd0,  32'h00800080, 4'd12},  // R8 accepted, R12 lane copies
    '{1'b0, 6'd0,  32'h60, 4'd8},
    '{1'b0, 6'd0,  32'h33, 4'd8},
    '{1'b1, 6'd10, 32'h12345678, 4'd8},
    '{1'b0, 6'd0,  32'hE8, 4'd9},
    '{1'b0, 6'd0,  32'h1, 4'd9},
    '{1'b0, 6'd12, 32'hAAAA0001, 4'd9},
    '{1'b0, 6'd13, 32'hBBBB0002, 4'd9},
    '{1'b0, 6'd0,  32'hD0, 4'd9},
    '{1'b1, 6'd0,  32'h00800080, 4'd9},   // R9 status during buffer
    '{1'b0, 6'd0,  32'hFF, 4'd9},
    '{1'b1, 6'd12, 32'hAAAA0001, 4'd9},
    '{1'b1, 6'd13, 32'hBBBB0002, 4'd9},
    '{1'b0, 6'd0,  32'hE8, 4'd9},
    '{1'b0, 6'd0,  32'h00010000, 4'd9},   // R9 count masked to 0
    '{1'b0, 6'd14, 32'h11112222, 4'd9},
    '{1'b0, 6'd0,  32'hD0, 4'd9},
    '{1'b0, 6'd0,  32'hFF, 4'd9},
    '{1'b1, 6'd14, 32'h11112222, 4'd9},
    '{1'b1, 6'd15, 32'hFFFFFFFF, 4'd9},
    '{1'b0, 6'd0,  32'hE8, 4'd9},
    '{1'b0, 6'd0,  32'h0, 4'd9},
    '{1'b0, 6'd15, 32'h55556666, 4'd9},
    '{1'b0, 6'd0,  32'h77, 4'd9},
    '{1'b1, 6'd15, 32'h55556666, 4'd9},   // R9 aborted confirm keeps data
    '{1'b0, 6'd16, 32'h20, 4'd6},
    '{1'b0, 6'd16, 32'h42, 4'd6},
    '{1'b1, 6'd20, 32'hFFFFFFFF, 4'd6},   // R6 illegal second write
    '{1'b0, 6'd0,  32'h70, 4'd11},
    '{1'b0, 6'd0,  32'hAB, 4'd11},
    '{1'b1, 6'd10, 32'h12345678, 4'd11}   // R11 unknown command
  };

  task automatic check(input int rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp, input int rq);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check(rq, rsp_data, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R13: watchdog expired, finished %0d expected 1", done);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int lowcnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state: ready high, status 0x80 in each lane
    @(negedge clk);
    check(1, 32'(req_ready), 32'd1);
    do_write(0, 32'h70);
    do_read(0, 32'h00800080, 1);
    do_write(0, 32'hFF);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].rd) do_read(VECS[i].addr, VECS[i].data, int'(VECS[i].rq));
      else            do_write(VECS[i].addr, VECS[i].data);
    end

    // R13 response timing
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 6'd10;
    @(negedge clk);
    req_valid = 1'b0;
    check(13, 32'(rsp_valid), 32'd1);
    check(13, rsp_data, 32'h12345678);
    @(negedge clk);
    check(13, 32'(rsp_valid), 32'd0);
    do_write(0, 32'hFF);
    check(13, 32'(rsp_valid), 32'd0);

    // R6 fill length and alignment
    do_write(33, 32'h20);
    lowcnt = 0;
    while (!req_ready && lowcnt < 100) begin lowcnt++; @(negedge clk); end
    check(6, 32'(lowcnt), 32'd8);
    do_write(33, 32'hD0);
    do_write(0, 32'hFF);
    do_read(32, 32'hFFFFFFFF, 6);
    do_read(39, 32'hFFFFFFFF, 6);

    // R10 read-only device
    read_only = 1'b1;
    do_write(0, 32'h50);
    do_write(0, 32'h40);
    do_write(10, 32'hDEADBEEF);
    do_read(0, 32'h00900090, 10);
    do_write(0, 32'hFF);
    do_read(10, 32'h12345678, 10);
    do_write(0, 32'h50);
    do_write(8, 32'h20);
    check(10, 32'(req_ready), 32'd1);
    do_write(8, 32'hD0);
    do_read(0, 32'h00A000A0, 10);
    do_write(0, 32'hFF);
    do_read(10, 32'h12345678, 10);
    do_write(0, 32'h50);
    do_write(0, 32'hE8);
    do_write(0, 32'h0);
    do_write(11, 32'h0);
    do_write(0, 32'hD0);
    do_read(0, 32'h00900090, 10);
    do_write(0, 32'hFF);
    do_read(11, 32'hCAFEF00D, 10);
    read_only = 1'b0;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule